// File: doc/BRIEF.md
# NAND Byte-Cycle Timing Generator

This block converts one-byte bus requests into the waveforms of an asynchronous 8-bit NAND flash bus. A request is a command latch, an address latch, a data write or a data read. For each request the block runs through four steps: an optional turnaround gap, a setup interval with chip enable asserted, a strobe-low interval, and a strobe-high interval. It then raises an acknowledge for one cycle. Every interval is a number of controller clock cycles taken from two configuration words. Each field of those words stores its count less a fixed offset.

A sequencer above this block issues one request at a time and waits for the acknowledge. For reads, the captured byte is presented alongside the acknowledge. The gap before a request depends on the kind of the previous completed request. A read that follows a latch cycle, a read that follows a data write, and a data write that follows an address each wait for their own delay. All other pairs go straight to setup.

Top module: `nand_cycle_timer`

## Requirements
- R1: After reset and whenever no request is in progress, chip enable, write strobe and read strobe are high, both latch enables are low, the data bus is not driven and the acknowledge is low.
- R2: The interval lengths in cycles are decoded as follows. From word A: read-low = bits 3:0 + 1, read-high = bits 5:4 + 1, write-low = bits 11:8 + 1, write-high = bits 13:12 + 1, setup = bits 15:14 + 2, write-to-read gap = bits 19:16 + 1, latch-to-read gap = bits 23:20 + 3. From word B: address-to-write gap = bits 3:0 + 3. This holds for all-zero and all-one fields.
- R3: Request kind encoding is 0 command, 1 address, 2 data write, 3 data read. For the setup interval of a request, chip enable is low and both strobes are high. The command latch enable is high only for kind 0 and the address latch enable only for kind 1. For kinds 0 to 2, the request byte is driven on the data bus.
- R4: For kinds 0 to 2, the write strobe is low for the write-low count and then high for the write-high count. During that time chip enable, the latch enable and the driven byte stay as in setup.
- R5: For kind 3, the read strobe is low for the read-low count and then high for the read-high count, with the bus not driven. The byte on the data input is captured on the clock edge that ends the read-low interval.
- R6: In the cycle after the strobe-high interval, the acknowledge is high for exactly one cycle with every bus line idle. During that cycle the returned byte equals the byte captured by the most recent read.
- R7: A read whose previous completed request was a command or an address is preceded by a latch-to-read gap with the bus idle.
- R8: A read whose previous completed request was a data write is preceded by a write-to-read gap with the bus idle.
- R9: A data write whose previous completed request was an address is preceded by an address-to-write gap with the bus idle.
- R10: Every other pair of requests, and the first request after reset, goes to setup in the cycle after the request is accepted.
- R11: A request presented while a cycle is in progress is ignored and changes no bus waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tim_cfg_a | input | 32 | Timing word A (strobe, setup and read-gap fields) |
| tim_cfg_b | input | 32 | Timing word B (address-to-write gap field) |
| req_valid | input | 1 | Request strobe, accepted only while idle |
| req_kind | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_byte | input | 8 | Byte to place on the bus for kinds 0 to 2 |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_byte | output | 8 | Byte captured by the last read |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus input value |

## Verification
The assertions assume that the timing words stay constant from the acceptance of a request until its acknowledge. They also assume that the flash side's data input has no bearing on the bus-control outputs. The bench changes the timing words only while the block is idle and its expectation queue is empty. During each read, the bench drives the correct byte on the data input only in the last read-low cycle and drives its complement before and after it. It also pulses a second request mid-cycle to show that requests raised while busy are ignored.

// File: rtl/nand_cyc_pkg.sv
package nand_cyc_pkg;

    localparam int unsigned FLD_W = 4;
    localparam int unsigned MAX_OFS = 3;
    localparam int unsigned CNT_W = $clog2((2 ** FLD_W) + MAX_OFS);

    typedef enum logic [1:0] {
        K_CMD = 2'd0,
        K_ADR = 2'd1,
        K_WR  = 2'd2,
        K_RD  = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_GAP   = 3'd1,
        PH_SETUP = 3'd2,
        PH_LOW   = 3'd3,
        PH_HIGH  = 3'd4,
        PH_ACK   = 3'd5
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] wr_lo;
        logic [CNT_W-1:0] wr_hi;
        logic [CNT_W-1:0] rd_lo;
        logic [CNT_W-1:0] rd_hi;
        logic [CNT_W-1:0] wr2rd;
        logic [CNT_W-1:0] lat2rd;
        logic [CNT_W-1:0] adr2wr;
    } tim_t;

endpackage

// File: rtl/nand_cyc_decode.sv
module nand_cyc_decode
    import nand_cyc_pkg::*;
#(
    parameter int unsigned CFG_W     = 32,
    parameter int unsigned OFS_PLAIN = 1,
    parameter int unsigned OFS_SETUP = 2,
    parameter int unsigned OFS_TURN  = 3
) (
    input  logic [CFG_W-1:0] cfg_a,
    input  logic [CFG_W-1:0] cfg_b,
    output tim_t             tim
);
    localparam int unsigned RDLO_LSB  = 0;
    localparam int unsigned RDHI_LSB  = 4;
    localparam int unsigned WRLO_LSB  = 8;
    localparam int unsigned WRHI_LSB  = 12;
    localparam int unsigned SETUP_LSB = 14;
    localparam int unsigned W2R_LSB   = 16;
    localparam int unsigned L2R_LSB   = 20;
    localparam int unsigned A2W_LSB   = 0;
    localparam int unsigned NARROW_W  = 2;

    function automatic logic [CNT_W-1:0] widen(input logic [FLD_W-1:0] f,
                                              input int unsigned ofs);
        return CNT_W'(f) + CNT_W'(ofs);
    endfunction

    logic cfg_unused;
    assign cfg_unused = ^{cfg_a[CFG_W-1:L2R_LSB+FLD_W], cfg_b[CFG_W-1:A2W_LSB+FLD_W]};

    always_comb begin
        tim.rd_lo  = widen(cfg_a[RDLO_LSB +: FLD_W], OFS_PLAIN);
        tim.rd_hi  = widen(FLD_W'(cfg_a[RDHI_LSB +: NARROW_W]), OFS_PLAIN);
        tim.wr_lo  = widen(cfg_a[WRLO_LSB +: FLD_W], OFS_PLAIN);
        tim.wr_hi  = widen(FLD_W'(cfg_a[WRHI_LSB +: NARROW_W]), OFS_PLAIN);
        tim.setup  = widen(FLD_W'(cfg_a[SETUP_LSB +: NARROW_W]), OFS_SETUP);
        tim.wr2rd  = widen(cfg_a[W2R_LSB +: FLD_W], OFS_PLAIN);
        tim.lat2rd = widen(cfg_a[L2R_LSB +: FLD_W], OFS_TURN);
        tim.adr2wr = widen(cfg_b[A2W_LSB +: FLD_W], OFS_TURN);
    end

endmodule

// File: rtl/nand_cyc_gap.sv
module nand_cyc_gap
    import nand_cyc_pkg::*;
(
    input  logic             prev_vld,
    input  kind_e            prev_kind,
    input  kind_e            next_kind,
    input  logic [CNT_W-1:0] wr2rd,
    input  logic [CNT_W-1:0] lat2rd,
    input  logic [CNT_W-1:0] adr2wr,
    output logic [CNT_W-1:0] gap
);
    always_comb begin
        gap = '0;
        if (prev_vld) begin
            unique case (next_kind)
                K_RD: begin
                    if (prev_kind == K_CMD || prev_kind == K_ADR) gap = lat2rd;
                    else if (prev_kind == K_WR)                   gap = wr2rd;
                end
                K_WR: begin
                    if (prev_kind == K_ADR) gap = adr2wr;
                end
                default: gap = '0;
            endcase
        end
    end

endmodule

// File: rtl/nand_cyc_seq.sv
module nand_cyc_seq
    import nand_cyc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  kind_e             req_kind,
    input  logic [DATA_W-1:0] req_byte,
    input  logic [CNT_W-1:0]  gap,
    input  logic [CNT_W-1:0]  setup,
    input  logic [CNT_W-1:0]  wr_lo,
    input  logic [CNT_W-1:0]  wr_hi,
    input  logic [CNT_W-1:0]  rd_lo,
    input  logic [CNT_W-1:0]  rd_hi,
    input  logic [DATA_W-1:0] dq_in,
    output phase_e            phase,
    output kind_e             kind,
    output logic [DATA_W-1:0] byte_out,
    output logic [DATA_W-1:0] rd_byte,
    output logic              prev_vld,
    output kind_e             prev_kind
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        kind_e             kind;
        logic [DATA_W-1:0] byt;
        logic [DATA_W-1:0] rd;
        logic              prev_vld;
        kind_e             prev_kind;
    } st_t;

    st_t st_d, st_q;
    logic last_q;
    logic is_rd_q;

    assign last_q  = (st_q.cnt == '0);
    assign is_rd_q = (st_q.kind == K_RD);

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.kind = req_kind;
                    st_d.byt  = req_byte;
                    if (gap != '0) begin
                        st_d.phase = PH_GAP;
                        st_d.cnt   = gap - ONE;
                    end else begin
                        st_d.phase = PH_SETUP;
                        st_d.cnt   = setup - ONE;
                    end
                end
            end
            PH_GAP: begin
                if (last_q) begin
                    st_d.phase = PH_SETUP;
                    st_d.cnt   = setup - ONE;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            PH_SETUP: begin
                if (last_q) begin
                    st_d.phase = PH_LOW;
                    st_d.cnt   = (is_rd_q ? rd_lo : wr_lo) - ONE;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            PH_LOW: begin
                if (last_q) begin
                    st_d.phase = PH_HIGH;
                    st_d.cnt   = (is_rd_q ? rd_hi : wr_hi) - ONE;
                    if (is_rd_q) st_d.rd = dq_in;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            PH_HIGH: begin
                if (last_q) begin
                    st_d.phase     = PH_ACK;
                    st_d.prev_vld  = 1'b1;
                    st_d.prev_kind = st_q.kind;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            PH_ACK:  st_d.phase = PH_IDLE;
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase     <= PH_IDLE;
            st_q.cnt       <= '0;
            st_q.kind      <= K_CMD;
            st_q.byt       <= '0;
            st_q.rd        <= '0;
            st_q.prev_vld  <= 1'b0;
            st_q.prev_kind <= K_CMD;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase     = st_q.phase;
    assign kind      = st_q.kind;
    assign byte_out  = st_q.byt;
    assign rd_byte   = st_q.rd;
    assign prev_vld  = st_q.prev_vld;
    assign prev_kind = st_q.prev_kind;

endmodule

// File: rtl/nand_cycle_timer.sv
module nand_cycle_timer
    import nand_cyc_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CFG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  tim_cfg_a,
    input  logic [CFG_W-1:0]  tim_cfg_b,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_byte,
    output logic              req_ack,
    output logic [DATA_W-1:0] rsp_byte,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DATA_W-1:0] nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [DATA_W-1:0] nand_dq_in
);
    tim_t              tim;
    logic [CNT_W-1:0]  gap;
    phase_e            phase;
    kind_e             kind;
    kind_e             prev_kind;
    logic              prev_vld;
    logic [DATA_W-1:0] byte_q;
    logic [DATA_W-1:0] rd_q;
    kind_e             new_kind;
    logic              on_bus;
    logic              wr_type;

    assign new_kind = kind_e'(req_kind);

    nand_cyc_decode #(
        .CFG_W (CFG_W)
    ) u_decode (
        .cfg_a (tim_cfg_a),
        .cfg_b (tim_cfg_b),
        .tim   (tim)
    );

    nand_cyc_gap u_gap (
        .prev_vld  (prev_vld),
        .prev_kind (prev_kind),
        .next_kind (new_kind),
        .wr2rd     (tim.wr2rd),
        .lat2rd    (tim.lat2rd),
        .adr2wr    (tim.adr2wr),
        .gap       (gap)
    );

    nand_cyc_seq #(
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (new_kind),
        .req_byte  (req_byte),
        .gap       (gap),
        .setup     (tim.setup),
        .wr_lo     (tim.wr_lo),
        .wr_hi     (tim.wr_hi),
        .rd_lo     (tim.rd_lo),
        .rd_hi     (tim.rd_hi),
        .dq_in     (nand_dq_in),
        .phase     (phase),
        .kind      (kind),
        .byte_out  (byte_q),
        .rd_byte   (rd_q),
        .prev_vld  (prev_vld),
        .prev_kind (prev_kind)
    );

    // Bus decode from registered state only.
    assign on_bus  = (phase == PH_SETUP) || (phase == PH_LOW) || (phase == PH_HIGH);
    assign wr_type = (kind != K_RD);

    assign nand_ce_n   = !on_bus;
    assign nand_cle    = on_bus && (kind == K_CMD);
    assign nand_ale    = on_bus && (kind == K_ADR);
    assign nand_we_n   = !((phase == PH_LOW) && wr_type);
    assign nand_re_n   = !((phase == PH_LOW) && !wr_type);
    assign nand_dq_oe  = on_bus && wr_type;
    assign nand_dq_out = nand_dq_oe ? byte_q : '0;
    assign req_ack     = (phase == PH_ACK);
    assign rsp_byte    = rd_q;

endmodule

// File: rtl/nand_cycle_timer_chk.sv
module nand_cycle_timer_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ack,
    input logic              nand_ce_n,
    input logic              nand_cle,
    input logic              nand_ale,
    input logic              nand_we_n,
    input logic              nand_re_n,
    input logic [DATA_W-1:0] nand_dq_out,
    input logic              nand_dq_oe
);
    // R1: deselected chip means idle control lines
    assert_deselect_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        nand_ce_n |-> (!nand_cle && !nand_ale && nand_we_n && nand_re_n && !nand_dq_oe));

    // R3: only one latch enable at a time
    assert_latch_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R3: a strobe only pulses while chip enable is low
    assert_strobe_in_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    // R4: write and read strobes never low together
    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    // R4: driven byte holds steady while the bus stays selected and driven
    assert_dq_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_ce_n && nand_dq_oe && $past(!nand_ce_n && nand_dq_oe)) |-> $stable(nand_dq_out));

    // R5: bus released during a read strobe
    assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);

    // R6: acknowledge lasts one cycle
    assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    // R6: acknowledge comes with an idle bus
    assert_ack_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (nand_ce_n && nand_we_n && nand_re_n && !nand_dq_oe));

    // R6: acknowledge directly follows a selected cycle
    assert_ack_after_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ack) |-> $past(!nand_ce_n));

endmodule

bind nand_cycle_timer nand_cycle_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ack     (req_ack),
    .nand_ce_n   (nand_ce_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_dq_out (nand_dq_out),
    .nand_dq_oe  (nand_dq_oe)
);

// File: tb/nand_cycle_timer_bench.sv
module nand_cycle_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_a = '0;
    logic [31:0] cfg_b = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [7:0]  req_byte = '0;
    logic [7:0]  dq_in = '0;
    logic        req_ack, ce_n, cle, ale, we_n, re_n, dq_oe;
    logic [7:0]  rsp_byte, dq_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_cycle_timer u_nand_cycle_timer (
        .clk(clk), .rst_n(rst_n), .tim_cfg_a(cfg_a), .tim_cfg_b(cfg_b),
        .req_valid(req_valid), .req_kind(req_kind), .req_byte(req_byte),
        .req_ack(req_ack), .rsp_byte(rsp_byte), .nand_ce_n(ce_n),
        .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
        .nand_dq_out(dq_out), .nand_dq_oe(dq_oe), .nand_dq_in(dq_in)
    );

    typedef struct {
        logic       ce_n, cle, ale, we_n, re_n, oe, ack;
        logic [7:0] dq;
        bit         chk_rd;
        logic [7:0] rd;
        int         tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    int   idle_tag = 1;
    int   tag_over = 0;
    bit   prev_vld = 0;
    int   prev_kind = 0;
    bit   done = 0;

    function automatic void push(int n, logic ce_n_e, logic cle_e, logic ale_e,
                                 logic we_e, logic re_e, logic oe_e, logic [7:0] dq_e,
                                 logic ack_e, bit chk_rd, logic [7:0] rd_e, int tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.ce_n = ce_n_e; e.cle = cle_e; e.ale = ale_e; e.we_n = we_e;
            e.re_n = re_e; e.oe = oe_e; e.dq = dq_e; e.ack = ack_e;
            e.chk_rd = chk_rd; e.rd = rd_e;
            e.tag = (tag_over != 0) ? tag_over : tag;
            q.push_back(e);
        end
    endfunction

    // Per-cycle comparison, sampled after the active edge.
    initial begin
        forever begin
            exp_t e;
            bit   bad;
            @(posedge clk);
            #2;
            if (q.size() != 0 && rst_n) e = q.pop_front();
            else begin
                e.ce_n = 1; e.cle = 0; e.ale = 0; e.we_n = 1; e.re_n = 1;
                e.oe = 0; e.dq = 0; e.ack = 0; e.chk_rd = 0; e.rd = 0;
                e.tag = idle_tag;   // R1 idle bus, R11 when a stray request was raised
            end
            checks++;
            bad = (ce_n !== e.ce_n) || (cle !== e.cle) || (ale !== e.ale) ||
                  (we_n !== e.we_n) || (re_n !== e.re_n) || (dq_oe !== e.oe) ||
                  (req_ack !== e.ack) || (e.oe && (dq_out !== e.dq)) ||
                  (e.chk_rd && (rsp_byte !== e.rd));
            if (bad) begin
                failures++;
                $display("FAIL R%0d t=%0t actual ce_n=%b cle=%b ale=%b we_n=%b re_n=%b oe=%b dq=%h ack=%b rd=%h expected ce_n=%b cle=%b ale=%b we_n=%b re_n=%b oe=%b dq=%h ack=%b rd=%h",
                         e.tag, $time, ce_n, cle, ale, we_n, re_n, dq_oe, dq_out, req_ack, rsp_byte,
                         e.ce_n, e.cle, e.ale, e.we_n, e.re_n, e.oe, e.dq, e.ack, e.rd);
            end
        end
    end

    // Issue one request, building the expected waveform from the requirements.
    task automatic issue(int kind, logic [7:0] b, logic [7:0] rdval, bit poke);
        int ts, wlo, whi, rlo, rhi, w2r, l2r, a2w, gap, lo, hi, gtag, total, lowlast;
        bit wr;
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        ts  = ((cfg_a >> 14) & 3) + 2;     // R2 field decode
        rlo = (cfg_a & 15) + 1;
        rhi = ((cfg_a >> 4) & 3) + 1;
        wlo = ((cfg_a >> 8) & 15) + 1;
        whi = ((cfg_a >> 12) & 3) + 1;
        w2r = ((cfg_a >> 16) & 15) + 1;
        l2r = ((cfg_a >> 20) & 15) + 3;
        a2w = (cfg_b & 15) + 3;
        gap = 0; gtag = 10;
        if (prev_vld && kind == 3 && (prev_kind == 0 || prev_kind == 1)) begin gap = l2r; gtag = 7; end // R7
        else if (prev_vld && kind == 3 && prev_kind == 2) begin gap = w2r; gtag = 8; end               // R8
        else if (prev_vld && kind == 2 && prev_kind == 1) begin gap = a2w; gtag = 9; end               // R9
        wr = (kind != 3);
        lo = wr ? wlo : rlo;
        hi = wr ? whi : rhi;
        push(gap, 1, 0, 0, 1, 1, 0, 8'h00, 0, 0, 8'h00, gtag);
        // R3 setup, R10 when there was no gap
        push(ts, 0, kind == 0, kind == 1, 1, 1, wr, b, 0, 0, 8'h00, (gap == 0) ? 10 : 3);
        // R4 write strobe, R5 read strobe
        push(lo, 0, kind == 0, kind == 1, !wr, wr, wr, b, 0, 0, 8'h00, wr ? 4 : 5);
        push(hi, 0, kind == 0, kind == 1, 1, 1, wr, b, 0, 0, 8'h00, wr ? 4 : 5);
        // R6 acknowledge, returned byte checked on reads
        push(1, 1, 0, 0, 1, 1, 0, 8'h00, 1, !wr, rdval, 6);
        prev_vld = 1; prev_kind = kind;
        req_valid = 1; req_kind = 2'(kind); req_byte = b;
        dq_in = ~rdval;
        total = gap + ts + lo + hi;
        lowlast = gap + ts + lo - 1;
        for (int j = 0; j <= total; j++) begin
            @(negedge clk);
            if (j == 0) req_valid = 0;
            if (poke && j == 2) begin   // R11 stray request while busy
                idle_tag = 11;
                req_valid = 1; req_kind = 2'(3 - kind); req_byte = ~b;
            end
            if (poke && j == 3) req_valid = 0;
            if (!wr && j == lowlast) dq_in = rdval;       // R5 capture edge
            if (!wr && j == lowlast + 1) dq_in = ~rdval;
        end
    endtask

    initial begin
        cfg_a = (32'd2 << 0) | (32'd1 << 4) | (32'd1 << 8) | (32'd0 << 12) |
                (32'd1 << 14) | (32'd2 << 16) | (32'd1 << 20) | (32'hA << 28);
        cfg_b = 32'd2;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        issue(0, 8'h70, 8'h00, 0);   // first request: R10
        issue(3, 8'h00, 8'hC3, 0);   // read after command: R7
        issue(0, 8'h00, 8'h00, 0);
        issue(1, 8'h12, 8'h00, 0);
        issue(1, 8'h34, 8'h00, 0);   // address after address: R10
        issue(0, 8'h30, 8'h00, 0);
        issue(3, 8'h00, 8'h5E, 0);   // R7
        issue(2, 8'hA5, 8'h00, 0);   // write after read: R10
        issue(2, 8'h5A, 8'h00, 1);   // write after write, stray request: R11
        issue(3, 8'h00, 8'h81, 0);   // read after write: R8
        issue(1, 8'h77, 8'h00, 0);
        issue(2, 8'h3C, 8'h00, 0);   // write after address: R9
        idle_tag = 1;
        while (q.size() != 0) @(negedge clk);
        // R2 minimum fields
        tag_over = 2; cfg_a = 32'h0; cfg_b = 32'h0;
        issue(1, 8'h01, 8'h00, 0);
        issue(2, 8'h02, 8'h00, 0);
        issue(3, 8'h00, 8'h99, 0);
        issue(0, 8'hFF, 8'h00, 0);
        issue(3, 8'h00, 8'h66, 0);
        while (q.size() != 0) @(negedge clk);
        // R2 maximum fields
        cfg_a = 32'hFFFF_FFFF; cfg_b = 32'hFFFF_FFFF;
        issue(1, 8'hE1, 8'h00, 0);
        issue(2, 8'hE2, 8'h00, 0);
        issue(3, 8'h00, 8'h4B, 0);
        issue(1, 8'hE3, 8'h00, 0);
        issue(3, 8'h00, 8'hB4, 1);
        tag_over = 0;
        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired, actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule